// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects up to 32 interrupt lines and presents one active-high request to a processor. Every line carries its own mode word (a 3-bit priority and a trigger type) and its own 32-bit vector word. Software reaches all of this through a simple register bus with address, write data, write enable, read enable and read data. It gates lines through a mask. It can raise or drop a pending state through command registers where a 1 in a bit position acts on that line.

Reading the vector register both returns the handler vector of the best candidate and acknowledges that candidate. The line number and priority of the acknowledged line go onto an 8-entry in-service stack. While a line sits on top of the stack, only a strictly higher priority can interrupt again. An end-of-interrupt write removes the top entry, so nested handlers unwind in the reverse order of their acknowledgement. When nothing qualifies, a vector read returns a programmable spurious value and leaves the stack untouched.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset the mask is all zero, every software pending flag is clear, the in-service stack is empty (in-service number reads 0), the spurious word reads 0, every vector word reads 0, every mode word reads 0x40 (level-high, priority 0) and irq_o is low.
- R2: A write to the enable command (0x010) sets the mask bits where write data is 1. A write to the disable command (0x014) clears them. Zero bits leave the mask unchanged. The mask reads at 0x00C.
- R3: A write to the set command (0x018) marks the lines at 1-bits as pending (software trigger). A write to the clear command (0x01C) removes that state. The pending vector reads at 0x008.
- R4: With mode bits [6:5] = 11 (rising edge) or 01 (falling edge), a line becomes pending on the selected input edge and stays pending after the input returns, until cleared or acknowledged.
- R5: With mode bits [6:5] = 10 (level-high) or 00 (level-low), the pending bit of a line follows its input level.
- R6: irq_o is high exactly when some enabled pending line has a priority (mode bits [2:0], 7 highest) strictly above the priority on top of the in-service stack, or any enabled pending line exists while the stack is empty.
- R7: A read of 0x000 returns, on the cycle after the read strobe, the vector word of the qualifying line with the highest priority. Among lines of equal priority the lowest line number wins.
- R8: That read acknowledges the winner: it goes on top of the stack, the in-service register (0x004) reads its number, and its latched pending flag is cleared.
- R9: A read of 0x000 with no qualifying line returns the spurious word (read and written at 0x024) and does not change the stack.
- R10: A write to end-of-interrupt (0x020) removes the top stack entry. Eight such writes empty a full stack, and a write with an empty stack has no effect.
- R11: Mode words sit at 0x100 + 4n and vector words at 0x180 + 4n. A mode word keeps only bits [6:5] and [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt source lines |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_re |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupt in-service stack shows up in the in-service number that is read after every acknowledge and every end-of-interrupt. A stack depth that is off by one changes irq_o on the first cycle after a pop, because a lower-priority line that is already pending either unmasks or stays blocked. A pending flag that fails to latch, or fails to clear on acknowledge, shows at the pending register within three cycles of the input edge. Wrong arbitration shows up in the vector word returned on the very next cycle, for both equal and unequal priorities.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
package nic_pkg;
  localparam int PRIO_W = 3;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'b00,
    TRIG_FALL   = 2'b01,
    TRIG_LVL_HI = 2'b10,
    TRIG_RISE   = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e             trig;
    logic [PRIO_W-1:0] prio;
  } mode_t;

  // register byte offsets
  localparam int OFF_VECT = 'h000;
  localparam int OFF_CUR  = 'h004;
  localparam int OFF_PEND = 'h008;
  localparam int OFF_MASK = 'h00C;
  localparam int OFF_EN   = 'h010;
  localparam int OFF_DIS  = 'h014;
  localparam int OFF_SETP = 'h018;
  localparam int OFF_CLRP = 'h01C;
  localparam int OFF_EOI  = 'h020;
  localparam int OFF_SPUR = 'h024;
  localparam int OFF_MODE = 'h100;
  localparam int OFF_VEC  = 'h180;

  localparam mode_t MODE_RESET = '{trig: TRIG_LVL_HI, prio: '0};

  function automatic logic is_edge(trig_e t);
    return t[0];
  endfunction

  function automatic logic level_hit(trig_e t, logic cur);
    return !t[0] && (cur == t[1]);
  endfunction

  function automatic logic edge_hit(trig_e t, logic cur, logic prev);
    return t[0] && (t[1] ? (cur && !prev) : (!cur && prev));
  endfunction

  function automatic logic [31:0] pack_mode(mode_t m);
    return {25'b0, m.trig, 2'b00, m.prio};
  endfunction

  function automatic mode_t unpack_mode(logic [31:0] w);
    mode_t m;
    m.trig = trig_e'(w[6:5]);
    m.prio = w[2:0];
    return m;
  endfunction

  // level that a request must exceed: 0 when nothing is in service
  function automatic logic [PRIO_W:0] ceiling(logic valid, logic [PRIO_W-1:0] prio);
    return valid ? ({1'b0, prio} + 1'b1) : '0;
  endfunction
endpackage

// File: rtl/nic_src_bank.sv
`timescale 1ns/1ps
module nic_src_bank
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  mode_we,
  input  logic [IDX_W-1:0]      mode_idx,
  input  mode_t                 mode_wdata,
  input  logic [NUM_SRC-1:0]    set_cmd,
  input  logic [NUM_SRC-1:0]    clr_cmd,
  input  logic [NUM_SRC-1:0]    ack_oh,
  output mode_t [NUM_SRC-1:0]   modes_o,
  output logic  [NUM_SRC-1:0]   pend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic  in_q, in_prev, flag_q;
    mode_t mode_q;
    logic  edge_evt;

    assign edge_evt = edge_hit(mode_q.trig, in_q, in_prev);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q    <= 1'b0;
        in_prev <= 1'b0;
        flag_q  <= 1'b0;
        mode_q  <= MODE_RESET;
      end else begin
        in_q    <= src_i[i];
        in_prev <= in_q;
        if (mode_we && mode_idx == IDX_W'(i)) mode_q <= mode_wdata;
        if (edge_evt || set_cmd[i])           flag_q <= 1'b1;
        else if (clr_cmd[i] || ack_oh[i])     flag_q <= 1'b0;
      end
    end

    assign modes_o[i] = mode_q;
    assign pend_o[i]  = flag_q | level_hit(mode_q.trig, in_q);

    // R8: an acknowledged edge line drops its pending state
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_oh[i] && is_edge(mode_q.trig) && !edge_evt && !set_cmd[i] && !mode_we)
        |=> !pend_o[i]);
    // R3: a clear command removes a software-only pending state
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd[i] && is_edge(mode_q.trig) && !edge_evt && !mode_we) |=> !pend_o[i]);
  end
endmodule

// File: rtl/nic_arbiter.sv
`timescale 1ns/1ps
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    req,
  input  mode_t [NUM_SRC-1:0]   modes,
  input  logic                  top_valid,
  input  logic [PRIO_W-1:0]     top_prio,
  output logic                  any_o,
  output logic [IDX_W-1:0]      win_idx_o,
  output logic [PRIO_W-1:0]     win_prio_o
);
  logic [PRIO_W:0] floor_lvl;
  assign floor_lvl = ceiling(top_valid, top_prio);

  always_comb begin
    any_o      = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && ceiling(1'b1, modes[i].prio) > floor_lvl &&
          (!any_o || modes[i].prio > win_prio_o)) begin
        any_o      = 1'b1;
        win_idx_o  = IDX_W'(i);
        win_prio_o = modes[i].prio;
      end
    end
  end

  // R6: a winner is always an enabled pending line
  assert_win_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req[win_idx_o]);
  // R6: no request at all means no interrupt
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !any_o);
endmodule

// File: rtl/nic_nest_stack.sv
`timescale 1ns/1ps
module nic_nest_stack
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DEPTH   = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic              top_valid,
  output logic [IDX_W-1:0]  top_idx,
  output logic [PRIO_W-1:0] top_prio,
  output logic [CNT_W-1:0]  depth_o
);
  logic [IDX_W-1:0]  idx_mem  [DEPTH];
  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  top_ptr;

  assign top_ptr   = PTR_W'(cnt_q - CNT_W'(1));
  assign top_valid = (cnt_q != '0);
  assign top_idx   = top_valid ? idx_mem[top_ptr]  : '0;
  assign top_prio  = top_valid ? prio_mem[top_ptr] : '0;
  assign depth_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        idx_mem[k]  <= '0;
        prio_mem[k] <= '0;
      end
    end else if (push && cnt_q < CNT_W'(DEPTH)) begin
      idx_mem[PTR_W'(cnt_q)]  <= push_idx;
      prio_mem[PTR_W'(cnt_q)] <= push_prio;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop && top_valid) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R10: strictly rising priorities keep the stack within its depth
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));
  // R6: a nested entry always outranks the one below it
  assert_nest_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && top_valid) |-> (push_prio > top_prio));
  // R10: a pop on a non-empty stack removes exactly one entry
  assert_pop_drains_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && top_valid) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R10: a pop on an empty stack changes nothing
  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !top_valid) |=> (cnt_q == '0));
endmodule

// File: rtl/nested_irq_ctrl.sv
`timescale 1ns/1ps
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_VECT = ADDR_W'(OFF_VECT);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFF_CUR);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFF_DIS);
  localparam logic [ADDR_W-1:0] A_SETP = ADDR_W'(OFF_SETP);
  localparam logic [ADDR_W-1:0] A_CLRP = ADDR_W'(OFF_CLRP);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(OFF_EOI);
  localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(OFF_SPUR);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_MODE_END = ADDR_W'(OFF_MODE + 4 * NUM_SRC);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFF_VEC);
  localparam logic [ADDR_W-1:0] A_VEC_END  = ADDR_W'(OFF_VEC + 4 * NUM_SRC);

  // named decode events
  logic               mode_hit, vec_hit, ack_fire, eoi_fire, wr_en_cmd, wr_dis_cmd;
  logic [IDX_W-1:0]   reg_idx;
  logic [NUM_SRC-1:0] mask_q, pend, set_cmd, clr_cmd, ack_oh, wdata_src;
  logic [DATA_W-1:0]  vec_q [NUM_SRC];
  logic [DATA_W-1:0]  spur_q, rd_mux;
  mode_t [NUM_SRC-1:0] modes;
  logic               arb_any, top_valid;
  logic [IDX_W-1:0]   win_idx, top_idx;
  logic [PRIO_W-1:0]  win_prio, top_prio;
  logic [CNT_W-1:0]   depth;

  // regions are aligned to 4*2^IDX_W, so the low address bits index the line
  assign reg_idx   = IDX_W'(bus_addr >> 2);
  assign mode_hit  = (bus_addr >= A_MODE) && (bus_addr < A_MODE_END) && (bus_addr[1:0] == 2'b00);
  assign vec_hit   = (bus_addr >= A_VEC)  && (bus_addr < A_VEC_END)  && (bus_addr[1:0] == 2'b00);
  assign wdata_src = bus_wdata[NUM_SRC-1:0];
  assign wr_en_cmd  = bus_we && bus_addr == A_EN;
  assign wr_dis_cmd = bus_we && bus_addr == A_DIS;
  assign set_cmd   = (bus_we && bus_addr == A_SETP) ? wdata_src : '0;
  assign clr_cmd   = (bus_we && bus_addr == A_CLRP) ? wdata_src : '0;
  assign ack_fire  = bus_re && bus_addr == A_VECT && arb_any;
  assign ack_oh    = ack_fire ? (NUM_SRC'(1) << win_idx) : '0;
  assign eoi_fire  = bus_we && bus_addr == A_EOI;
  assign irq_o     = arb_any;

  nic_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .mode_we(bus_we && mode_hit), .mode_idx(reg_idx),
    .mode_wdata(unpack_mode(bus_wdata)),
    .set_cmd(set_cmd), .clr_cmd(clr_cmd), .ack_oh(ack_oh),
    .modes_o(modes), .pend_o(pend)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(pend & mask_q), .modes(modes),
    .top_valid(top_valid), .top_prio(top_prio),
    .any_o(arb_any), .win_idx_o(win_idx), .win_prio_o(win_prio)
  );

  nic_nest_stack #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(ack_fire), .push_idx(win_idx), .push_prio(win_prio),
    .pop(eoi_fire),
    .top_valid(top_valid), .top_idx(top_idx), .top_prio(top_prio),
    .depth_o(depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      spur_q <= '0;
      for (int k = 0; k < NUM_SRC; k++) vec_q[k] <= '0;
    end else if (bus_we) begin
      if (wr_en_cmd)             mask_q <= mask_q | wdata_src;
      if (wr_dis_cmd)            mask_q <= mask_q & ~wdata_src;
      if (bus_addr == A_SPUR)    spur_q <= bus_wdata;
      if (vec_hit)               vec_q[reg_idx] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (mode_hit)     rd_mux = DATA_W'(pack_mode(modes[reg_idx]));
    else if (vec_hit) rd_mux = vec_q[reg_idx];
    else begin
      case (bus_addr)
        A_VECT:  rd_mux = arb_any ? vec_q[win_idx] : spur_q;
        A_CUR:   rd_mux = DATA_W'(top_idx);
        A_PEND:  rd_mux = DATA_W'(pend);
        A_MASK:  rd_mux = DATA_W'(mask_q);
        A_SPUR:  rd_mux = spur_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  // R8: every acknowledge deepens the stack by one
  assert_ack_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (depth == $past(depth) + CNT_W'(1)));
  // R9: a vector read without a candidate leaves the stack alone
  assert_spur_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_VECT && !irq_o && !bus_we) |=> $stable(depth));
  // R2: the mask only moves on enable or disable commands
  assert_mask_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_cmd || wr_dis_cmd) |=> $stable(mask_q));
endmodule

// File: tb/nested_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nested_irq_ctrl_tb;
  localparam int NS = 32;
  localparam logic [31:0] VBASE = 32'hC0DE_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  nested_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: compares each read result one cycle after its strobe
  always @(posedge clk) rd_seen <= re;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) check(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); check({31'b0, irq}, {31'b0, exp}, tag);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got hang exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(10'h00C, 32'h0, "R1 mask");
    rd(10'h008, 32'h0, "R1 pend");
    rd(10'h004, 32'h0, "R1 cur");
    rd(10'h024, 32'h0, "R1 spur");
    rd(10'h000, 32'h0, "R1 vect spurious");
    rd(10'h100, 32'h40, "R1 mode0");
    rd(10'h184, 32'h0, "R1 vec1");
    // R2 mask commands
    wr(10'h010, 32'hF5); rd(10'h00C, 32'hF5, "R2 enable");
    wr(10'h014, 32'h05); rd(10'h00C, 32'hF0, "R2 disable");
    wr(10'h010, 32'h00); rd(10'h00C, 32'hF0, "R2 zero bits");
    // R3 software pending
    wr(10'h018, 32'h300); rd(10'h008, 32'h300, "R3 set");
    wr(10'h01C, 32'h100); rd(10'h008, 32'h200, "R3 clear one");
    wr(10'h01C, 32'h200); rd(10'h008, 32'h0, "R3 clear all");
    // R11 map and vectors
    for (int n = 0; n < NS; n++) wr(10'h180 + 10'(4 * n), VBASE + 32'(n));
    wr(10'h17C, 32'hFFFF_FFFF); rd(10'h17C, 32'h67, "R11 mode fields");
    rd(10'h1B4, VBASE + 32'd13, "R11 vec13");
    // R5 level modes
    wr(10'h110, 32'h42);
    src[4] = 1'b1; settle(); rd(10'h008, 32'h10, "R5 level-high set");
    src[4] = 1'b0; settle(); rd(10'h008, 32'h0, "R5 level-high drop");
    src[5] = 1'b1; settle(); wr(10'h114, 32'h03);
    rd(10'h008, 32'h0, "R5 level-low idle");
    src[5] = 1'b0; settle(); rd(10'h008, 32'h20, "R5 level-low set");
    src[5] = 1'b1; settle(); rd(10'h008, 32'h0, "R5 level-low drop");
    // R4 edge modes
    wr(10'h118, 32'h61);
    src[6] = 1'b1; settle(); rd(10'h008, 32'h40, "R4 rise latch");
    src[6] = 1'b0; settle(); rd(10'h008, 32'h40, "R4 rise held");
    wr(10'h01C, 32'h40); rd(10'h008, 32'h0, "R4 rise cleared");
    src[7] = 1'b1; settle(); wr(10'h11C, 32'h21);
    src[7] = 1'b0; settle(); rd(10'h008, 32'h80, "R4 fall latch");
    src[7] = 1'b1; settle(); rd(10'h008, 32'h80, "R4 fall held");
    wr(10'h01C, 32'h80); rd(10'h008, 32'h0, "R4 fall cleared");
    wr(10'h014, 32'hFF);
    chk_irq(1'b0, "R6 quiet");
    // R8 edge acknowledge
    wr(10'h010, 32'h40);
    src[6] = 1'b1; settle(); chk_irq(1'b1, "R6 edge irq");
    rd(10'h000, VBASE + 32'd6, "R7 edge vector");
    rd(10'h008, 32'h0, "R8 edge flag cleared");
    rd(10'h004, 32'd6, "R8 cur edge");
    wr(10'h020, 32'h0); src[6] = 1'b0; wr(10'h014, 32'h40);
    // nesting: priorities 10:1 11:5 12:5 13:7
    wr(10'h024, 32'h5A5A);
    wr(10'h128, 32'h41); wr(10'h12C, 32'h45); wr(10'h130, 32'h45); wr(10'h134, 32'h47);
    wr(10'h010, 32'h3C00);
    wr(10'h018, 32'h400); chk_irq(1'b1, "R6 first");
    rd(10'h000, VBASE + 32'd10, "R7 first");
    rd(10'h004, 32'd10, "R8 cur 10");
    chk_irq(1'b0, "R6 nothing left");
    wr(10'h018, 32'h1800); chk_irq(1'b1, "R6 higher");
    rd(10'h000, VBASE + 32'd11, "R7 tie lowest");
    rd(10'h004, 32'd11, "R8 cur 11");
    chk_irq(1'b0, "R6 equal blocked");
    rd(10'h000, 32'h5A5A, "R9 spurious");
    rd(10'h004, 32'd11, "R9 stack kept");
    wr(10'h018, 32'h2000);
    rd(10'h000, VBASE + 32'd13, "R7 top prio");
    rd(10'h004, 32'd13, "R8 cur 13");
    wr(10'h020, 32'h0); rd(10'h004, 32'd11, "R10 pop 13");
    chk_irq(1'b0, "R6 still blocked");
    wr(10'h020, 32'h0); rd(10'h004, 32'd10, "R10 pop 11");
    chk_irq(1'b1, "R6 unblocked");
    rd(10'h000, VBASE + 32'd12, "R7 pending 12");
    wr(10'h020, 32'h0); wr(10'h020, 32'h0);
    rd(10'h004, 32'd0, "R10 empty");
    wr(10'h020, 32'h0); rd(10'h004, 32'd0, "R10 empty eoi");
    chk_irq(1'b0, "R6 idle");
    // masked line never interrupts
    wr(10'h018, 32'h0010_0000); chk_irq(1'b0, "R6 masked");
    rd(10'h008, 32'h0010_0000, "R3 masked pending");
    rd(10'h000, 32'h5A5A, "R9 masked spurious");
    wr(10'h01C, 32'h0010_0000);
    // R10 full eight-deep nesting
    for (int k = 0; k < 8; k++) wr(10'h140 + 10'(4 * k), 32'h40 | 32'(k));
    wr(10'h010, 32'h00FF_0000);
    for (int k = 0; k < 8; k++) begin
      wr(10'h018, 32'h1 << (16 + k));
      rd(10'h000, VBASE + 32'(16 + k), "R10 nest vector");
      rd(10'h004, 32'(16 + k), "R10 nest cur");
    end
    for (int k = 7; k >= 0; k--) begin
      wr(10'h020, 32'h0);
      rd(10'h004, (k > 0) ? 32'(15 + k) : 32'd0, "R10 unwind");
    end
    rd(10'h000, 32'h5A5A, "R10 drained spurious");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule